// File: doc/BRIEF.md
# Channel Receive Transaction Acceptor

This block terminates the inbound side of a host-to-accelerator streaming channel on the user logic side. The link side raises a request line to announce a transaction and presents three header fields with it: a word count, a start offset and a flag marking the final transaction of a sequence. The block captures the header once, answers with a one-cycle acknowledge, and then pulls data beats out of a first-word-fall-through FIFO interface by raising a read-enable. A beat is taken only in a cycle where the FIFO's valid and the block's read-enable are both high.

Every taken beat is forwarded, one cycle later, to a simple downstream port together with a per-word keep mask. Each beat carries DATA_W/32 words of 32 bits, and the block counts words until the captured length is covered. On the final beat the unused upper words are masked off, read-enable drops, and a one-cycle completion pulse presents the captured offset and last flag. A zero-length transaction is acknowledged and completes at once. The downstream ready input throttles the drain: read-enable is never raised while it is low.

Top module: `rx_txn_acceptor`

## Requirements
- R1: While idle, a high `req_i` captures `len_i`, `off_i` and `last_i`; in the next cycle `ack_o` is high for exactly one cycle; header inputs changed after that capture have no effect on the transaction.
- R2: `ren_o` is low while idle and during the acknowledge cycle, and is high only while draining and `out_ready_i` is high.
- R3: A beat is taken only in a cycle with `valid_i` and `ren_o` both high; in the following cycle `out_valid_o` is high for one cycle and `out_data_o` equals the taken beat.
- R4: Each taken beat adds DATA_W/32 to the received word count; bit i of `out_keep_o` covers word i (data bits 32*i upward) and is set exactly when that word lies inside the captured length, so the final beat of a length that is not a multiple of DATA_W/32 has its upper keep bits clear.
- R5: When the count reaches the captured length, `ren_o` is low from the next cycle on, and `done_o` is high for one cycle, in the same cycle as the final beat's `out_valid_o`, with `done_off_o` and `done_last_o` equal to the captured offset and flag; later FIFO data is not taken.
- R6: A length of zero is acknowledged and `done_o` follows in the cycle right after the acknowledge, with no beat taken.
- R7: After completion, a `req_i` that is still high starts no new transaction; the block waits for `req_i` to go low before accepting again.
- R8: A synchronous active-high `rst` returns the block to idle with `ack_o`, `ren_o`, `done_o` and `out_valid_o` low, also in the middle of a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Transaction request from the link side |
| len_i | input | 32 | Transaction length in 32-bit words |
| off_i | input | 31 | Start offset in 32-bit words |
| last_i | input | 1 | Final transaction of a sequence |
| ack_o | output | 1 | One-cycle acknowledge of a request |
| data_i | input | DATA_W | FIFO head data |
| valid_i | input | 1 | FIFO head data is valid |
| ren_o | output | 1 | Read-enable toward the FIFO |
| out_ready_i | input | 1 | Downstream can take a beat |
| out_data_o | output | DATA_W | Forwarded beat |
| out_keep_o | output | DATA_W/32 | Per-word valid mask of the forwarded beat |
| out_valid_o | output | 1 | Forwarded beat is valid |
| done_o | output | 1 | One-cycle completion pulse |
| done_off_o | output | 31 | Captured offset, meaningful with done_o |
| done_last_o | output | 1 | Captured last flag, meaningful with done_o |

## Verification
The assertions assume the link side holds `req_i` high from the request until at least the completion cycle, so the acknowledge is never seen against a vanished request, and that the FIFO supplies exactly as many beats as the length needs before it goes empty. The stimulus keeps the request high throughout each transaction, feeds exactly ceil(length/words-per-beat) beats with random gaps on `valid_i` and random stalls on `out_ready_i`, and only offers surplus data after completion to show it is left alone. Header inputs are scrambled during draining, and reset is applied once in the middle of a drain.

// File: rtl/rx_acc_pkg.sv
package rx_acc_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned LEN_W  = 32;
    localparam int unsigned OFF_W  = 31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK,
        ST_DRAIN,
        ST_DONE,
        ST_HOLD
    } acc_state_e;

endpackage

// File: rtl/rx_acc_ctrl.sv
module rx_acc_ctrl
    import rx_acc_pkg::*;
#(
    parameter int unsigned HLEN_W = LEN_W,
    parameter int unsigned HOFF_W = OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [HLEN_W-1:0] len_i,
    input  logic [HOFF_W-1:0] off_i,
    input  logic              last_i,
    input  logic              take_i,
    input  logic              reached_i,
    input  logic              out_ready_i,
    output logic              ack_o,
    output logic              ren_o,
    output logic              done_o,
    output logic              clear_o,
    output logic [HLEN_W-1:0] len_o,
    output logic [HOFF_W-1:0] off_o,
    output logic              last_o
);

    typedef struct packed {
        acc_state_e        state;
        logic [HLEN_W-1:0] len;
        logic [HOFF_W-1:0] off;
        logic              last;
    } ctrl_t;

    ctrl_t cur_q, cur_d;

    always_comb begin
        cur_d   = cur_q;
        clear_o = 1'b0;
        case (cur_q.state)
            ST_IDLE: begin
                if (req_i) begin
                    cur_d.state = ST_ACK;
                    cur_d.len   = len_i;
                    cur_d.off   = off_i;
                    cur_d.last  = last_i;
                    clear_o     = 1'b1;
                end
            end
            ST_ACK: begin
                cur_d.state = (cur_q.len == '0) ? ST_DONE : ST_DRAIN;
            end
            ST_DRAIN: begin
                if (take_i && reached_i) begin
                    cur_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                cur_d.state = req_i ? ST_HOLD : ST_IDLE;
            end
            ST_HOLD: begin
                if (!req_i) begin
                    cur_d.state = ST_IDLE;
                end
            end
            default: cur_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.state <= ST_IDLE;
            cur_q.len   <= '0;
            cur_q.off   <= '0;
            cur_q.last  <= 1'b0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign ack_o  = (cur_q.state == ST_ACK);
    assign ren_o  = (cur_q.state == ST_DRAIN) && out_ready_i;
    assign done_o = (cur_q.state == ST_DONE);
    assign len_o  = cur_q.len;
    assign off_o  = cur_q.off;
    assign last_o = cur_q.last;

    // R1: acknowledge lasts exactly one cycle
    p_ack_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o);

    // R2: read-enable never without downstream ready, never while acknowledging
    p_ren_gated_r2: assert property (@(posedge clk) disable iff (rst)
        ren_o |-> (out_ready_i && !ack_o));

    // R5: completion is a single-cycle pulse
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6: zero length completes right after the acknowledge
    p_zero_len_r6: assert property (@(posedge clk) disable iff (rst)
        (ack_o && (len_o == '0)) |=> done_o);

    // R7: a request still high at completion does not start a new transaction
    p_hold_no_ack_r7: assert property (@(posedge clk) disable iff (rst)
        (done_o && req_i) |=> !ack_o);

endmodule

// File: rtl/rx_acc_tally.sv
module rx_acc_tally
    import rx_acc_pkg::*;
#(
    parameter int unsigned WPB    = 2,
    parameter int unsigned CLEN_W = LEN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              step_i,
    input  logic [CLEN_W-1:0] len_i,
    output logic              reached_o,
    output logic [CLEN_W-1:0] rem_o
);

    localparam int unsigned CNT_W = CLEN_W + 1;

    logic [CNT_W-1:0] count_q, count_d;
    logic [CNT_W-1:0] next_sum;
    logic [CNT_W-1:0] len_ext;

    assign len_ext  = {1'b0, len_i};
    assign next_sum = count_q + CNT_W'(WPB);

    always_comb begin
        count_d = count_q;
        if (clear_i) begin
            count_d = '0;
        end else if (step_i) begin
            count_d = next_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign reached_o = (next_sum >= len_ext);
    assign rem_o     = (count_q >= len_ext) ? '0 : CLEN_W'(len_ext - count_q);

    // R4: the count never runs more than one beat past the length
    p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, count_q} <= ({1'b0, len_ext} + (CNT_W + 1)'(WPB))));

endmodule

// File: rtl/rx_acc_beat_reg.sv
module rx_acc_beat_reg
    import rx_acc_pkg::*;
#(
    parameter int unsigned DW     = 64,
    parameter int unsigned BLEN_W = LEN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [DW-1:0]     data_i,
    input  logic [BLEN_W-1:0] rem_i,
    output logic [DW-1:0]     data_o,
    output logic [DW/WORD_W-1:0] keep_o,
    output logic              valid_o
);

    localparam int unsigned NW = DW / WORD_W;

    typedef struct packed {
        logic [DW-1:0] data;
        logic [NW-1:0] keep;
        logic          valid;
    } beat_t;

    beat_t beat_q, beat_d;
    logic [NW-1:0] keep_n;

    for (genvar g = 0; g < NW; g++) begin : g_keep
        assign keep_n[g] = (rem_i > BLEN_W'(g));
    end

    always_comb begin
        beat_d       = beat_q;
        beat_d.valid = load_i;
        if (load_i) begin
            beat_d.data = data_i;
            beat_d.keep = keep_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_d;
        end
    end

    assign data_o  = beat_q.data;
    assign keep_o  = beat_q.keep;
    assign valid_o = beat_q.valid;

    // R3: a loaded beat is presented in the next cycle, and only then
    p_load_shows_r3: assert property (@(posedge clk) disable iff (rst)
        load_i |=> valid_o);
    p_no_load_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> !valid_o);

    // R4: a presented beat always keeps its lowest word
    p_keep_low_r4: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> keep_o[0]);

endmodule

// File: rtl/rx_txn_acceptor.sv
module rx_txn_acceptor
    import rx_acc_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_i,
    input  logic [31:0]              len_i,
    input  logic [30:0]              off_i,
    input  logic                     last_i,
    output logic                     ack_o,
    input  logic [DATA_W-1:0]        data_i,
    input  logic                     valid_i,
    output logic                     ren_o,
    input  logic                     out_ready_i,
    output logic [DATA_W-1:0]        out_data_o,
    output logic [DATA_W/32-1:0]     out_keep_o,
    output logic                     out_valid_o,
    output logic                     done_o,
    output logic [30:0]              done_off_o,
    output logic                     done_last_o
);

    localparam int unsigned WPB = DATA_W / WORD_W;

    logic             take;
    logic             reached;
    logic             clear;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] rem;

    assign take = valid_i && ren_o;

    rx_acc_ctrl #(
        .HLEN_W (LEN_W),
        .HOFF_W (OFF_W)
    ) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req_i),
        .len_i       (len_i),
        .off_i       (off_i),
        .last_i      (last_i),
        .take_i      (take),
        .reached_i   (reached),
        .out_ready_i (out_ready_i),
        .ack_o       (ack_o),
        .ren_o       (ren_o),
        .done_o      (done_o),
        .clear_o     (clear),
        .len_o       (len_q),
        .off_o       (done_off_o),
        .last_o      (done_last_o)
    );

    rx_acc_tally #(
        .WPB    (WPB),
        .CLEN_W (LEN_W)
    ) tally_i (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (clear),
        .step_i    (take),
        .len_i     (len_q),
        .reached_o (reached),
        .rem_o     (rem)
    );

    rx_acc_beat_reg #(
        .DW     (DATA_W),
        .BLEN_W (LEN_W)
    ) beat_i (
        .clk     (clk),
        .rst     (rst),
        .load_i  (take),
        .data_i  (data_i),
        .rem_i   (rem),
        .data_o  (out_data_o),
        .keep_o  (out_keep_o),
        .valid_o (out_valid_o)
    );

    // R3: every taken beat is forwarded in the next cycle
    p_take_forwarded_r3: assert property (@(posedge clk) disable iff (rst)
        (valid_i && ren_o) |=> out_valid_o);

    // R5: no read-enable once the transaction has completed
    p_ren_off_at_done_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !ren_o);

endmodule

// File: tb/rx_txn_acceptor_tb_top.sv
module rx_txn_acceptor_tb_top;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned DW  = 64;
    localparam int unsigned WPB = DW / 32;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           req_i = 1'b0;
    logic [31:0]    len_i = '0;
    logic [30:0]    off_i = '0;
    logic           last_i = 1'b0;
    logic           ack_o;
    logic [DW-1:0]  data_i = '0;
    logic           valid_i = 1'b0;
    logic           ren_o;
    logic           out_ready_i = 1'b0;
    logic [DW-1:0]  out_data_o;
    logic [WPB-1:0] out_keep_o;
    logic           out_valid_o;
    logic           done_o;
    logic [30:0]    done_off_o;
    logic           done_last_o;

    int unsigned nvec  = 0;
    int unsigned nfail = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_txn_acceptor #(.DATA_W(DW)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req_i),
        .len_i       (len_i),
        .off_i       (off_i),
        .last_i      (last_i),
        .ack_o       (ack_o),
        .data_i      (data_i),
        .valid_i     (valid_i),
        .ren_o       (ren_o),
        .out_ready_i (out_ready_i),
        .out_data_o  (out_data_o),
        .out_keep_o  (out_keep_o),
        .out_valid_o (out_valid_o),
        .done_o      (done_o),
        .done_off_o  (done_off_o),
        .done_last_o (done_last_o)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] beat_pat(input int unsigned txn, input int unsigned b);
        logic [DW-1:0] v;
        for (int i = 0; i < WPB; i++) begin
            v[32*i +: 32] = {txn[7:0], b[15:0], 8'(i)};
        end
        return v;
    endfunction

    function automatic logic [WPB-1:0] exp_keep(input int unsigned len, input int unsigned b);
        logic [WPB-1:0] k;
        for (int i = 0; i < WPB; i++) begin
            k[i] = (len > b * WPB + i);
        end
        return k;
    endfunction

    // One transaction; stop_at_beat > 0 applies reset after that many beats
    task automatic run_txn(input int unsigned txn, input int unsigned len,
                           input logic [30:0] off, input bit last,
                           input bit hold, input int unsigned stop_at_beat);
        int unsigned nbeats;
        int unsigned taken;
        bit          pend;
        int unsigned pend_idx;
        bit          first;
        bit          exp_done;
        nbeats = (len + WPB - 1) / WPB;
        @(negedge clk);
        req_i = 1'b1; len_i = len; off_i = off; last_i = last;
        valid_i = 1'b0; out_ready_i = 1'b1;
        @(negedge clk);
        chk(ack_o == 1'b1, "R1 ack after request", ack_o, 1);
        chk(ren_o == 1'b0, "R2 no ren during ack", ren_o, 0);
        // R1: scramble the header, it must not matter
        len_i = $urandom; off_i = 31'($urandom); last_i = ~last;
        taken = 0; pend = 1'b0; pend_idx = 0; first = 1'b1;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            if (!first) begin
                chk(ack_o == 1'b0, "R1 ack single cycle", ack_o, 0);
            end
            chk(out_valid_o == pend, "R3 out_valid", out_valid_o, pend);
            if (pend) begin
                chk(out_data_o == beat_pat(txn, pend_idx), "R3 out_data",
                    out_data_o, beat_pat(txn, pend_idx));
                chk(out_keep_o == exp_keep(len, pend_idx), "R4 keep mask",
                    out_keep_o, exp_keep(len, pend_idx));
            end
            exp_done = (len == 0) ? first : (pend && (pend_idx == nbeats - 1));
            chk(done_o == exp_done, (len == 0) ? "R6 zero-length done" : "R5 done timing",
                done_o, exp_done);
            if (exp_done) begin
                chk(done_off_o == off, "R5 done offset", done_off_o, off);
                chk(done_last_o == last, "R5 done last", done_last_o, last);
                break;
            end
            if (stop_at_beat != 0 && taken == stop_at_beat) begin
                rst = 1'b1; valid_i = 1'b1; req_i = 1'b1;
                @(negedge clk);
                chk({ack_o, ren_o, done_o, out_valid_o} == 4'b0, "R8 reset mid-transaction",
                    {ack_o, ren_o, done_o, out_valid_o}, 0);
                rst = 1'b0; req_i = 1'b0; valid_i = 1'b0;
                @(negedge clk);
                chk(ack_o == 1'b0, "R8 idle after reset", ack_o, 0);
                return;
            end
            first = 1'b0;
            out_ready_i = (($urandom % 10) < 7);
            valid_i = (taken < nbeats) ? (($urandom % 4) != 0) : 1'b0;
            data_i = beat_pat(txn, taken);
            #1;
            if (ren_o && !out_ready_i) begin
                chk(1'b0, "R2 ren without ready", ren_o, 0);
            end
            pend = valid_i && ren_o;
            pend_idx = taken;
            if (pend) taken++;
        end
        // Completion cycle: offer surplus data, must be left alone
        valid_i = 1'b1; out_ready_i = 1'b1; data_i = '1;
        #1;
        chk(ren_o == 1'b0, (len == 0) ? "R6 no ren at zero length" : "R5 ren low at done", ren_o, 0);
        if (hold) begin
            for (int h = 0; h < 3; h++) begin
                @(negedge clk);
                chk(ack_o == 1'b0, "R7 no re-accept while req high", ack_o, 0);
                chk(ren_o == 1'b0 && out_valid_o == 1'b0, "R7 idle while holding",
                    {ren_o, out_valid_o}, 0);
            end
        end
        req_i = 1'b0;
        @(negedge clk);
        chk(out_valid_o == 1'b0, "R5 surplus data not taken", out_valid_o, 0);
        chk(ren_o == 1'b0, "R5 ren stays low", ren_o, 0);
        valid_i = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        req_i = 1'b1;
        repeat (3) @(negedge clk);
        chk({ack_o, ren_o, done_o, out_valid_o} == 4'b0, "R8 reset state",
            {ack_o, ren_o, done_o, out_valid_o}, 0);
        rst = 1'b0; req_i = 1'b0;
        @(negedge clk);
        chk(ack_o == 1'b0, "R8 idle after reset", ack_o, 0);

        run_txn(1, 0, 31'h0000_0123, 1'b1, 1'b0, 0);
        run_txn(2, 1, 31'h7FFF_FFFF, 1'b0, 1'b0, 0);
        run_txn(3, WPB, 31'h10, 1'b1, 1'b0, 0);
        run_txn(4, WPB + 1, 31'h20, 1'b0, 1'b1, 0);
        run_txn(5, 7, 31'h30, 1'b1, 1'b0, 0);
        run_txn(6, 0, 31'h44, 1'b0, 1'b1, 0);
        run_txn(7, 20, 31'h55, 1'b0, 1'b0, 3);
        run_txn(8, 9, 31'h66, 1'b1, 1'b0, 0);
        for (int t = 0; t < 40; t++) begin
            run_txn(10 + t, $urandom % 41, 31'($urandom), 1'($urandom),
                    1'($urandom), 0);
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nvec++;
            nfail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule